// File: doc/BRIEF.md
# I2C Target Status Flag Controller

This block keeps the status flags of an I2C target interface and turns them into a combined interrupt line, transmit and receive DMA requests, and a low-power wakeup request. A bus engine feeds it single-cycle event strobes: START, repeated START and STOP detection, matches on two address comparators, general-call and alert-response matches, bit mismatches while transmitting, FIFO underrun and overrun, and a request for an ACK/NACK decision. It also feeds level signals for FIFO space, FIFO data, address data and engine activity.

Each flag has its own mix of capabilities. Level flags follow the FIFO state directly. Event flags are sticky and are cleared by write-one-to-clear strobes. The repeated-START and STOP flags record only bus conditions that follow an address match. The FIFO error flag is blocked while clock stretching is enabled. Dropping the enable forces every flag and every request to zero.

Top module: `i2c_tgt_flags`

## Requirements
- R1: After an asynchronous reset with every input low, status_o is all zeros and irq_o, wake_o, tx_dma_req_o and rx_dma_req_o are 0.
- R2: While enabled, status bit 9 equals tx_space_i, bit 10 equals rx_avail_i and bit 11 equals addr_avail_i in the same cycle. clr_i has no effect on these bits.
- R3: tx_dma_req_o = status bit 9 AND tx_dma_en_i. rx_dma_req_o = (bit 10 OR bit 11) AND rx_dma_en_i. No other flag requests DMA.
- R4: Event flags occupy status bits 0..8: ack request (0), repeated START (1), STOP (2), bit error (3), FIFO error (4), match 0 (5), match 1 (6), general call (7) and alert response (8). A set event shows in the cycle after its strobe. The flag then holds until clr_i[bit] is 1 on a clock edge. If a set and a clear arrive in the same cycle, the set wins.
- R5: Bit 1 sets on rstart_i and bit 2 sets on stop_i only when an address match (match0_i, match1_i, gcall_i or alert_i) arrived in an earlier cycle. A START, repeated START or STOP ends that matched state.
- R6: Bit 3 sets only when bit_mismatch_i and tx_active_i are both 1.
- R7: Bit 4 sets on tx_underrun_i, on rx_overrun_i, or on addr_overrun_i while rx_cfg_i = 1. It sets only while stretch_en_i = 0.
- R8: Bits 5..8 set from match0_i, match1_i, gcall_i and alert_i. They can drive irq_o but never wake_o.
- R9: Bit 12 equals engine_busy_i. Bit 13 sets on start_i and clears on stop_i, and start_i wins when both arrive together. Neither bit drives irq_o, wake_o or DMA.
- R10: irq_o is the OR over bits 0..11 of status bit AND irq_en_i[bit].
- R11: wake_o is the OR over bits 0..4 and 9..11 of status bit AND irq_en_i[bit].
- R12: While enable_i = 0, all status bits and all request outputs are 0. Event flags, the matched state and bus-busy are cleared, so nothing reappears when the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable |
| stretch_en_i | input | 1 | Clock stretching enabled (blocks FIFO error) |
| rx_cfg_i | input | 1 | Receive configuration; 1 lets address overrun count |
| start_i | input | 1 | START detected strobe |
| rstart_i | input | 1 | Repeated START detected strobe |
| stop_i | input | 1 | STOP detected strobe |
| match0_i | input | 1 | Address comparator 0 match strobe |
| match1_i | input | 1 | Address comparator 1 or range match strobe |
| gcall_i | input | 1 | General-call match strobe |
| alert_i | input | 1 | Alert-response address match strobe |
| ack_req_i | input | 1 | ACK/NACK decision may now be written |
| tx_active_i | input | 1 | Target is driving data |
| bit_mismatch_i | input | 1 | Sampled bus bit differs from driven bit |
| tx_underrun_i | input | 1 | Transmit FIFO underrun strobe |
| rx_overrun_i | input | 1 | Receive FIFO overrun strobe |
| addr_overrun_i | input | 1 | Address status overrun strobe |
| tx_space_i | input | 1 | Transmit data can be written |
| rx_avail_i | input | 1 | Receive data can be read |
| addr_avail_i | input | 1 | Received address can be read |
| engine_busy_i | input | 1 | Address or data transfer in progress |
| irq_en_i | input | 12 | Per-flag enable for bits 0..11 |
| clr_i | input | 9 | Write-one-to-clear for bits 0..8 |
| tx_dma_en_i | input | 1 | Transmit DMA enable |
| rx_dma_en_i | input | 1 | Receive DMA enable |
| status_o | output | 14 | Status word |
| irq_o | output | 1 | Combined interrupt |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| wake_o | output | 1 | Low-power wakeup request |

## Verification
The bench checks a set and a clear in the same cycle. A design where the clear wins would lose an event that software never saw. It sends STOP and repeated START with no earlier address match, and again right after one. A design without the match qualifier would raise bus-condition flags for traffic aimed at other targets. It also drives FIFO faults with clock stretching on, and address overrun with the receive configuration bit low; wrong gating there would report errors that cannot happen. A long random phase toggles the enable in the middle of activity. This catches flags that survive a disable, and match flags that leak into the wakeup line.

// File: rtl/i2c_tgt_flags_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_flags_pkg;
  localparam int NFLAG = 14;
  localparam int NEVT  = 9;   // sticky flags at bits 0..NEVT-1
  localparam int NIRQ  = 12;  // interrupt-capable bits 0..NIRQ-1
  localparam int F_ACK  = 0;
  localparam int F_RSTA = 1;
  localparam int F_STOP = 2;
  localparam int F_BERR = 3;
  localparam int F_FERR = 4;
  localparam int F_AM0  = 5;
  localparam int F_AM1  = 6;
  localparam int F_GC   = 7;
  localparam int F_ALRT = 8;
  localparam int F_TXD  = 9;
  localparam int F_RXD  = 10;
  localparam int F_ADR  = 11;
  localparam int F_BUSY = 12;
  localparam int F_BBSY = 13;
  localparam logic [NIRQ-1:0] WAKE_CAP = 12'hE1F;
endpackage

// File: rtl/i2c_tgt_evt_bank.sv
`timescale 1ns/1ps
module i2c_tgt_evt_bank #(
  parameter int N = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_o[g] <= 1'b0;
      else if (!enable_i)   flag_o[g] <= 1'b0;
      else if (set_i[g])    flag_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g])    flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_bus_track.sv
`timescale 1ns/1ps
module i2c_tgt_bus_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic start_i,
  input  logic rstart_i,
  input  logic stop_i,
  input  logic any_match_i,
  output logic matched_o,
  output logic bus_busy_o
);
  logic cond_seen;
  assign cond_seen = start_i | rstart_i | stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      matched_o  <= 1'b0;
      bus_busy_o <= 1'b0;
    end else if (!enable_i) begin
      matched_o  <= 1'b0;
      bus_busy_o <= 1'b0;
    end else begin
      if (cond_seen)        matched_o <= 1'b0;
      else if (any_match_i) matched_o <= 1'b1;
      if (start_i)          bus_busy_o <= 1'b1;
      else if (stop_i)      bus_busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_req_route.sv
`timescale 1ns/1ps
module i2c_tgt_req_route
  import i2c_tgt_flags_pkg::*;
(
  input  logic [NIRQ-1:0] flags_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic            tx_dma_en_i,
  input  logic            rx_dma_en_i,
  output logic            irq_o,
  output logic            wake_o,
  output logic            tx_dma_req_o,
  output logic            rx_dma_req_o
);
  logic [NIRQ-1:0] irq_term, wake_term;

  for (genvar g = 0; g < NIRQ; g++) begin : g_term
    assign irq_term[g] = flags_i[g] & irq_en_i[g];
    if (WAKE_CAP[g]) begin : g_wk
      assign wake_term[g] = irq_term[g];
    end else begin : g_nwk
      assign wake_term[g] = 1'b0;
    end
  end

  assign irq_o        = |irq_term;
  assign wake_o       = |wake_term;
  assign tx_dma_req_o = flags_i[F_TXD] & tx_dma_en_i;
  assign rx_dma_req_o = (flags_i[F_RXD] | flags_i[F_ADR]) & rx_dma_en_i;
endmodule

// File: rtl/i2c_tgt_flags.sv
`timescale 1ns/1ps
module i2c_tgt_flags
  import i2c_tgt_flags_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             stretch_en_i,
  input  logic             rx_cfg_i,
  input  logic             start_i,
  input  logic             rstart_i,
  input  logic             stop_i,
  input  logic             match0_i,
  input  logic             match1_i,
  input  logic             gcall_i,
  input  logic             alert_i,
  input  logic             ack_req_i,
  input  logic             tx_active_i,
  input  logic             bit_mismatch_i,
  input  logic             tx_underrun_i,
  input  logic             rx_overrun_i,
  input  logic             addr_overrun_i,
  input  logic             tx_space_i,
  input  logic             rx_avail_i,
  input  logic             addr_avail_i,
  input  logic             engine_busy_i,
  input  logic [NIRQ-1:0]  irq_en_i,
  input  logic [NEVT-1:0]  clr_i,
  input  logic             tx_dma_en_i,
  input  logic             rx_dma_en_i,
  output logic [NFLAG-1:0] status_o,
  output logic             irq_o,
  output logic             tx_dma_req_o,
  output logic             rx_dma_req_o,
  output logic             wake_o
);
  logic [NEVT-1:0]  evt_set, evt_q;
  logic             matched, bus_busy, any_match, fifo_fault;
  logic [NFLAG-1:0] raw;

  assign any_match  = match0_i | match1_i | gcall_i | alert_i;
  assign fifo_fault = tx_underrun_i | rx_overrun_i | (addr_overrun_i & rx_cfg_i);

  always_comb begin
    evt_set         = '0;
    evt_set[F_ACK]  = ack_req_i;
    evt_set[F_RSTA] = rstart_i & matched;
    evt_set[F_STOP] = stop_i & matched;
    evt_set[F_BERR] = bit_mismatch_i & tx_active_i;
    evt_set[F_FERR] = fifo_fault & ~stretch_en_i;
    evt_set[F_AM0]  = match0_i;
    evt_set[F_AM1]  = match1_i;
    evt_set[F_GC]   = gcall_i;
    evt_set[F_ALRT] = alert_i;
  end

  i2c_tgt_evt_bank #(.N(NEVT)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .set_i    (evt_set),
    .clr_i    (clr_i),
    .flag_o   (evt_q)
  );

  i2c_tgt_bus_track u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .start_i     (start_i),
    .rstart_i    (rstart_i),
    .stop_i      (stop_i),
    .any_match_i (any_match),
    .matched_o   (matched),
    .bus_busy_o  (bus_busy)
  );

  assign raw      = {bus_busy, engine_busy_i, addr_avail_i, rx_avail_i, tx_space_i, evt_q};
  assign status_o = enable_i ? raw : '0;

  i2c_tgt_req_route u_route (
    .flags_i      (status_o[NIRQ-1:0]),
    .irq_en_i     (irq_en_i),
    .tx_dma_en_i  (tx_dma_en_i),
    .rx_dma_en_i  (rx_dma_en_i),
    .irq_o        (irq_o),
    .wake_o       (wake_o),
    .tx_dma_req_o (tx_dma_req_o),
    .rx_dma_req_o (rx_dma_req_o)
  );
endmodule

// File: rtl/i2c_tgt_flags_chk.sv
`timescale 1ns/1ps
module i2c_tgt_flags_chk
  import i2c_tgt_flags_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             stretch_en_i,
  input logic             stop_i,
  input logic             ack_req_i,
  input logic [NEVT-1:0]  clr_i,
  input logic             tx_dma_en_i,
  input logic             rx_dma_en_i,
  input logic [NFLAG-1:0] status_o,
  input logic             irq_o,
  input logic             wake_o,
  input logic             tx_dma_req_o,
  input logic             rx_dma_req_o
);
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (status_o == '0 && !irq_o && !wake_o && !tx_dma_req_o && !rx_dma_req_o)); // R12

  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && ack_req_i |=> (!enable_i || status_o[F_ACK])); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && clr_i[F_ACK] && !ack_req_i |=> !status_o[F_ACK]); // R4

  AST_STOP_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && !stop_i |=> !$rose(status_o[F_STOP])); // R5

  AST_FERR_NO_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && stretch_en_i |=> !$rose(status_o[F_FERR])); // R7

  AST_TX_DMA_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o |-> (tx_dma_en_i && status_o[F_TXD])); // R3

  AST_RX_DMA_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o |-> (rx_dma_en_i && (status_o[F_RXD] || status_o[F_ADR]))); // R3

  AST_WAKE_IN_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> irq_o); // R11
endmodule

bind i2c_tgt_flags i2c_tgt_flags_chk u_chk (.*);

// File: tb/i2c_tgt_flags_tb.sv
`timescale 1ns/1ps
module i2c_tgt_flags_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 0, stretch_en_i = 0, rx_cfg_i = 0;
  logic start_i = 0, rstart_i = 0, stop_i = 0;
  logic match0_i = 0, match1_i = 0, gcall_i = 0, alert_i = 0, ack_req_i = 0;
  logic tx_active_i = 0, bit_mismatch_i = 0;
  logic tx_underrun_i = 0, rx_overrun_i = 0, addr_overrun_i = 0;
  logic tx_space_i = 0, rx_avail_i = 0, addr_avail_i = 0, engine_busy_i = 0;
  logic [11:0] irq_en_i = '0;
  logic [8:0]  clr_i = '0;
  logic tx_dma_en_i = 0, rx_dma_en_i = 0;
  logic [13:0] status_o;
  logic irq_o, tx_dma_req_o, rx_dma_req_o, wake_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  i2c_tgt_flags u_dut (.*);

  int vectors = 0, errors = 0;
  bit done = 0;
  bit [8:0] m_ev = '0;
  bit m_match = 0, m_bb = 0;

  function automatic bit [13:0] exp_status();
    if (!enable_i) return '0;
    return {m_bb, engine_busy_i, addr_avail_i, rx_avail_i, tx_space_i, m_ev};
  endfunction

  task automatic compare(input string tag);
    bit [13:0] st;
    bit e_irq, e_wake, e_tx, e_rx;
    st = exp_status();
    e_irq = 0; e_wake = 0;
    for (int i = 0; i < 12; i++) begin
      if (st[i] && irq_en_i[i]) begin
        e_irq = 1;
        if (i <= 4 || i >= 9) e_wake = 1;
      end
    end
    e_tx = st[9] && tx_dma_en_i;
    e_rx = (st[10] || st[11]) && rx_dma_en_i;
    vectors++;
    if (status_o !== st || irq_o !== e_irq || wake_o !== e_wake ||
        tx_dma_req_o !== e_tx || rx_dma_req_o !== e_rx) begin
      errors++;
      $display("FAIL %s: status=%h irq=%b wake=%b txd=%b rxd=%b expected status=%h irq=%b wake=%b txd=%b rxd=%b",
               tag, status_o, irq_o, wake_o, tx_dma_req_o, rx_dma_req_o,
               st, e_irq, e_wake, e_tx, e_rx);
    end
  endtask

  task automatic model_edge();
    bit [8:0] s;
    if (!rst_ni || !enable_i) begin
      m_ev = '0; m_match = 0; m_bb = 0;
      return;
    end
    s[0] = ack_req_i;
    s[1] = rstart_i && m_match;
    s[2] = stop_i && m_match;
    s[3] = tx_active_i && bit_mismatch_i;
    s[4] = !stretch_en_i && (tx_underrun_i || rx_overrun_i || (addr_overrun_i && rx_cfg_i));
    s[5] = match0_i; s[6] = match1_i; s[7] = gcall_i; s[8] = alert_i;
    for (int i = 0; i < 9; i++)
      if (s[i]) m_ev[i] = 1; else if (clr_i[i]) m_ev[i] = 0;
    if (start_i || rstart_i || stop_i) m_match = 0;
    else if (match0_i || match1_i || gcall_i || alert_i) m_match = 1;
    if (start_i) m_bb = 1; else if (stop_i) m_bb = 0;
  endtask

  task automatic cyc(input string tag);
    #1 compare(tag);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    {start_i, rstart_i, stop_i, match0_i, match1_i, gcall_i, alert_i, ack_req_i} = '0;
    {bit_mismatch_i, tx_underrun_i, rx_overrun_i, addr_overrun_i} = '0;
    clr_i = '0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    cyc("R1");
    @(negedge clk_i) rst_ni = 1'b1;
    cyc("R1");
    cyc("R1");
    // R2 level flags
    enable_i = 1; irq_en_i = '1;
    tx_space_i = 1; cyc("R2");
    rx_avail_i = 1; clr_i = '1; cyc("R2");
    tx_space_i = 0; addr_avail_i = 1; cyc("R2");
    rx_avail_i = 0; addr_avail_i = 0; cyc("R2");
    // R3 DMA
    tx_dma_en_i = 1; rx_dma_en_i = 1; tx_space_i = 1; cyc("R3");
    tx_dma_en_i = 0; addr_avail_i = 1; cyc("R3");
    ack_req_i = 1; cyc("R3"); cyc("R3");
    clr_i[0] = 1; tx_space_i = 0; addr_avail_i = 0; cyc("R3");
    // R4 sticky, clear, set wins
    ack_req_i = 1; cyc("R4"); cyc("R4"); cyc("R4");
    clr_i[0] = 1; ack_req_i = 1; cyc("R4"); cyc("R4");
    clr_i[0] = 1; cyc("R4"); cyc("R4");
    // R5 bus conditions need prior match
    stop_i = 1; cyc("R5"); rstart_i = 1; cyc("R5"); cyc("R5");
    match0_i = 1; cyc("R5"); stop_i = 1; cyc("R5"); cyc("R5");
    stop_i = 1; cyc("R5"); cyc("R5");
    gcall_i = 1; cyc("R5"); rstart_i = 1; cyc("R5"); cyc("R5");
    clr_i = '1; cyc("R5");
    // R6 bit error
    bit_mismatch_i = 1; cyc("R6"); cyc("R6");
    tx_active_i = 1; bit_mismatch_i = 1; cyc("R6"); cyc("R6");
    tx_active_i = 0; clr_i = '1; cyc("R6");
    // R7 FIFO error gating
    stretch_en_i = 1; tx_underrun_i = 1; rx_overrun_i = 1; cyc("R7"); cyc("R7");
    stretch_en_i = 0; addr_overrun_i = 1; cyc("R7"); cyc("R7");
    rx_cfg_i = 1; addr_overrun_i = 1; cyc("R7"); cyc("R7");
    clr_i = '1; rx_overrun_i = 1; cyc("R7"); cyc("R7");
    clr_i = '1; tx_underrun_i = 1; cyc("R7"); clr_i = '1; cyc("R7");
    // R8 match flags: irq but no wake
    irq_en_i = 12'h1E0;
    match1_i = 1; alert_i = 1; cyc("R8"); cyc("R8");
    irq_en_i = '1; cyc("R8");
    clr_i = '1; cyc("R8");
    // R9 busy flags never request anything
    engine_busy_i = 1; cyc("R9");
    start_i = 1; cyc("R9"); cyc("R9");
    start_i = 1; stop_i = 1; cyc("R9");
    stop_i = 1; cyc("R9"); engine_busy_i = 0; cyc("R9");
    // R10 / R11 enable masking
    irq_en_i = 12'h010; tx_underrun_i = 1; cyc("R10"); cyc("R11");
    irq_en_i = 12'h020; match0_i = 1; cyc("R10"); cyc("R11");
    irq_en_i = 12'h000; cyc("R10");
    // R12 disable clears everything
    irq_en_i = '1; tx_space_i = 1; start_i = 1; tx_dma_en_i = 1; cyc("R12");
    enable_i = 0; cyc("R12"); cyc("R12");
    enable_i = 1; cyc("R12");
    tx_space_i = 0;
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r, q;
      r = $urandom; q = $urandom;
      enable_i = (r[4:0] != 0);
      {start_i, rstart_i, stop_i} = r[7:5] & {3{r[31]}};
      {match0_i, match1_i, gcall_i, alert_i} = r[11:8] & {4{r[30]}};
      ack_req_i = r[12] & r[13];
      {tx_active_i, bit_mismatch_i} = r[15:14];
      {tx_underrun_i, rx_overrun_i, addr_overrun_i} = r[18:16] & {3{r[29]}};
      {stretch_en_i, rx_cfg_i} = r[20:19];
      {tx_space_i, rx_avail_i, addr_avail_i, engine_busy_i} = r[24:21];
      {tx_dma_en_i, rx_dma_en_i} = r[26:25];
      irq_en_i = q[11:0];
      clr_i = q[20:12] & {9{q[21]}};
      cyc("R10");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule